// File: doc/BRIEF.md
# Bit-Sliced Shift-and-Add Row Reducer

This block rebuilds the integer dot product of one logical matrix row when that row is held in a resistive crossbar as several physical rows. Each physical row stores a group of bits, one slice, of every weight. The input vector is applied in bit-serial steps. Every step delivers one unsigned quantized code per slice from the per-row converters. The block weights each code by its slice position, sums the slices, and folds the step sums into a wide accumulator, most significant input step first. When the final step of a row has been folded in, the complete sum leaves with a one-cycle strobe. A downstream arithmetic-code correction stage consumes that sum, so no per-slice correction is attempted here. A small additive error in a code reaches the output unchanged, scaled only by its slice and step weights.

A step is one beat with `step_valid` high. `step_first` marks the opening step of a row and `step_last` its closing step. Rows may follow each other with no idle cycle between them, and idle cycles are allowed inside a row.

Top module: `bitslice_reduce`

## Requirements
- R1: While reset is held and after it is released, before any step is closed, `row_valid` is 0 and `row_sum` is 0.
- R2: Slice k is bits [k*CODE_W +: CODE_W] of `slice_codes`, is read as unsigned and carries weight 2^(k*CELL_BITS) in the step sum.
- R3: Steps are applied most significant first: a row of n step sums S0..S(n-1) (S0 being the first) yields the sum over j of Sj * 2^((n-1-j)*STEP_BITS).
- R4: A step with `step_first` high discards everything accumulated before it, including an unfinished row.
- R5: A step with `step_last` high produces the row sum on `row_sum` with `row_valid` high for one cycle, exactly two clock edges after the edge that samples that step.
- R6: A cycle with `step_valid` low has no effect on the accumulation or on the outputs, whatever `step_first`, `step_last` and `slice_codes` carry.
- R7: The opening step of a new row is accepted in the cycle right after the closing step of the previous row, and consecutive rows each produce their own pulse.
- R8: Between pulses, `row_sum` holds the last reported row sum.
- R9: A step with both `step_first` and `step_last` high forms a one-step row whose sum is that step's weighted slice sum.
- R10: A row of STEPS steps with every code at its maximum is reported exactly, with no overflow of the ACC_W-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_valid | input | 1 | A step is present this cycle |
| step_first | input | 1 | The step opens a row |
| step_last | input | 1 | The step closes a row |
| slice_codes | input | SLICES*CODE_W | Converter codes, slice k at bits [k*CODE_W +: CODE_W] |
| row_sum | output | ACC_W | Reduced row sum, ACC_W = CODE_W + SLICES*CELL_BITS + STEPS*STEP_BITS |
| row_valid | output | 1 | One-cycle strobe marking a new row sum |

## Verification
The bench builds the block with its default parameters: eight slices of two bits per cell, ten-bit codes and sixteen one-bit input steps, giving a 42-bit result. That width is small enough for a 64-bit reference model yet large enough that a full-scale sixteen-step row, with every code at 1023, sets bits near the top of the accumulator, so a truncated sum or a wrong slice shift shows up. One-bit steps make the step shift differ from the slice shift of two, so a swap of the two weightings is visible, and sixteen steps allow rows of every length from one to the maximum, mixed with idle gaps and back-to-back starts.

// File: rtl/bitslice_reduce_pkg.sv
// Shared types for the bit-sliced row reducer.
package bitslice_reduce_pkg;

    // Framing flags that travel with a step through the pipeline.
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } step_tag_t;

endpackage

// File: rtl/slice_combiner.sv
// Stage 1 of the reducer: weights each slice code by its cell bit position
// and registers the slice sum together with the step framing flags.
// Assumes unsigned codes and SUM_W >= CODE_W + SLICES*CELL_BITS.
module slice_combiner
    import bitslice_reduce_pkg::*;
#(
    parameter int SLICES    = 8,
    parameter int CELL_BITS = 2,
    parameter int CODE_W    = 10,
    parameter int SUM_W     = CODE_W + SLICES * CELL_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  step_tag_t                in_tag,
    input  logic [SLICES*CODE_W-1:0] codes,
    output step_tag_t                out_tag,
    output logic [SUM_W-1:0]         out_sum
);

    localparam int PAD_W = SUM_W - CODE_W;

    logic [SUM_W-1:0] weighted [SLICES];
    logic [SUM_W-1:0] total;

    // One shifter per slice, shift set by the slice's bit position.
    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign weighted[g] = {{PAD_W{1'b0}}, codes[g*CODE_W +: CODE_W]} << (g * CELL_BITS);
    end

    // Adds the weighted slices.
    always_comb begin
        total = '0;
        for (int k = 0; k < SLICES; k++) begin
            total = total + weighted[k];
        end
    end

    // Registers the slice sum and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tag <= '0;
            out_sum <= '0;
        end else begin
            out_tag <= in_tag;
            out_sum <= total;
        end
    end

endmodule

// File: rtl/step_accumulator.sv
// Stage 2 of the reducer: folds slice sums across input steps, most
// significant step first, and frames the result with a one-cycle strobe.
// Assumes a row has at most as many steps as ACC_W was sized for.
module step_accumulator
    import bitslice_reduce_pkg::*;
#(
    parameter int SUM_W     = 26,
    parameter int ACC_W     = 42,
    parameter int STEP_BITS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_tag_t        tag,
    input  logic [SUM_W-1:0] sum,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);

    localparam int PAD_W = ACC_W - SUM_W;

    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_next;

    // Next accumulator value: restart on a first step, else shift and add.
    always_comb begin
        base     = tag.first ? '0 : acc_q;
        acc_next = (base << STEP_BITS) + {{PAD_W{1'b0}}, sum};
    end

    // Updates the accumulator on valid steps and publishes closed rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q        <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= tag.valid && tag.last;
            if (tag.valid) begin
                acc_q <= acc_next;
            end
            if (tag.valid && tag.last) begin
                result <= acc_next;
            end
        end
    end

endmodule

// File: rtl/bitslice_reduce.sv
// Top of the bit-sliced row reducer: slice weighting stage followed by the
// step accumulator. Two edges from a sampled closing step to its strobe.
// Assumes CELL_BITS within 1..5 and at most STEPS steps per row.
module bitslice_reduce
    import bitslice_reduce_pkg::*;
#(
    parameter  int SLICES    = 8,
    parameter  int CELL_BITS = 2,
    parameter  int CODE_W    = 10,
    parameter  int STEP_BITS = 1,
    parameter  int STEPS     = 16,
    localparam int SUM_W     = CODE_W + SLICES * CELL_BITS,
    localparam int ACC_W     = SUM_W + STEPS * STEP_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_valid,
    input  logic                     step_first,
    input  logic                     step_last,
    input  logic [SLICES*CODE_W-1:0] slice_codes,
    output logic [ACC_W-1:0]         row_sum,
    output logic                     row_valid
);

    step_tag_t        in_tag;
    step_tag_t        s1_tag;
    logic [SUM_W-1:0] s1_sum;
    logic [ACC_W-1:0] acc_q;

    // Packs the framing inputs.
    assign in_tag = '{valid: step_valid, first: step_first, last: step_last};

    slice_combiner #(
        .SLICES   (SLICES),
        .CELL_BITS(CELL_BITS),
        .CODE_W   (CODE_W),
        .SUM_W    (SUM_W)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_tag (in_tag),
        .codes  (slice_codes),
        .out_tag(s1_tag),
        .out_sum(s1_sum)
    );

    step_accumulator #(
        .SUM_W    (SUM_W),
        .ACC_W    (ACC_W),
        .STEP_BITS(STEP_BITS)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tag         (s1_tag),
        .sum         (s1_sum),
        .acc_q       (acc_q),
        .result      (row_sum),
        .result_valid(row_valid)
    );

endmodule

// File: rtl/bitslice_reduce_checker.sv
// Temporal checks for the row reducer, bound onto the top module.
module bitslice_reduce_checker
    import bitslice_reduce_pkg::*;
#(
    parameter int SUM_W = 26,
    parameter int ACC_W = 42
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_valid,
    input logic             step_last,
    input step_tag_t        s1_tag,
    input logic [SUM_W-1:0] s1_sum,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] row_sum,
    input logic             row_valid
);

    // R5
    close_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_tag.valid && s1_tag.last) |=> row_valid);

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> $past(step_valid && step_last, 2));

    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |-> $stable(row_sum));

    // R6
    idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_tag.valid |=> $stable(acc_q));

    // R9
    zero_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_tag.valid && s1_tag.first && s1_tag.last && s1_sum == '0) |=> (row_sum == '0));

endmodule

bind bitslice_reduce bitslice_reduce_checker #(
    .SUM_W(SUM_W),
    .ACC_W(ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_valid(step_valid),
    .step_last (step_last),
    .s1_tag    (s1_tag),
    .s1_sum    (s1_sum),
    .acc_q     (acc_q),
    .row_sum   (row_sum),
    .row_valid (row_valid)
);

// File: tb/tb_bitslice_reduce.sv
module tb_bitslice_reduce;

    localparam int SLICES    = 8;
    localparam int CELL_BITS = 2;
    localparam int CODE_W    = 10;
    localparam int STEP_BITS = 1;
    localparam int STEPS     = 16;
    localparam int ACC_W     = CODE_W + SLICES * CELL_BITS + STEPS * STEP_BITS;
    localparam int CW        = SLICES * CODE_W;
    localparam longint MASK  = (64'd1 << ACC_W) - 1;
    localparam longint CMAX  = (64'd1 << CODE_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_valid = 1'b0;
    logic             step_first = 1'b0;
    logic             step_last = 1'b0;
    logic [CW-1:0]    slice_codes = '0;
    logic [ACC_W-1:0] row_sum;
    logic             row_valid;

    int     n_checks = 0;
    int     n_fails = 0;
    bit     done = 1'b0;

    // Reference state and a two-deep expectation pipeline.
    longint m_acc = 0;
    longint m_held = 0;
    bit     d1_v = 0, d2_v = 0;
    longint d1_r = 0, d2_r = 0;
    string  d1_t = "R1", d2_t = "R1";

    always #4 clk = ~clk;

    bitslice_reduce #(
        .SLICES(SLICES), .CELL_BITS(CELL_BITS), .CODE_W(CODE_W),
        .STEP_BITS(STEP_BITS), .STEPS(STEPS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
        .step_first(step_first), .step_last(step_last),
        .slice_codes(slice_codes), .row_sum(row_sum), .row_valid(row_valid)
    );

    function automatic longint slice_sum(input logic [CW-1:0] c);
        longint s = 0;
        for (int k = 0; k < SLICES; k++)
            s += longint'(c[k*CODE_W +: CODE_W]) << (k * CELL_BITS);
        return s;
    endfunction

    function automatic logic [CW-1:0] rand_codes();
        logic [CW-1:0] c;
        for (int k = 0; k < SLICES; k++)
            c[k*CODE_W +: CODE_W] = CODE_W'($urandom);
        return c;
    endfunction

    task automatic check_outputs();
        n_checks++;
        if (row_valid !== d2_v) begin
            n_fails++;
            $display("FAIL %s: row_valid=%0d expected %0d", d2_t, row_valid, d2_v);
        end
        n_checks++;
        if (longint'(row_sum) !== d2_r) begin
            n_fails++;
            $display("FAIL %s: row_sum=%0h expected %0h", d2_t, row_sum, d2_r);
        end
    endtask

    // One cycle: check outputs due now, advance the model, drive the step.
    task automatic cyc(input bit v, input bit f, input bit l,
                       input logic [CW-1:0] c, input string tag);
        bit nv = 0;
        @(negedge clk);
        check_outputs();
        d2_v = d1_v; d2_r = d1_r; d2_t = d1_t;
        if (v) begin
            if (f) m_acc = slice_sum(c);
            else   m_acc = ((m_acc << STEP_BITS) + slice_sum(c)) & MASK;
            if (l) begin
                nv = 1;
                m_held = m_acc;
            end
        end
        d1_v = nv; d1_r = m_held; d1_t = tag;
        step_valid = v; step_first = f; step_last = l; slice_codes = c;
    endtask

    // Idle cycles with junk on the qualifying inputs (R6).
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++)
            cyc(0, 1'($urandom), 1'($urandom), rand_codes(), tag);
    endtask

    task automatic run_row(input int n, input string tag, input bit gaps, input bit full);
        for (int j = 0; j < n; j++) begin
            cyc(1, j == 0, j == n - 1, full ? '1 : rand_codes(), tag);
            if (gaps && j != n - 1 && ($urandom % 3) == 0) idle(1 + $urandom % 2, "R6");
        end
    endtask

    initial begin
        void'($urandom(32'h1D5E));
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        n_checks++;
        if (row_valid !== 1'b0 || row_sum !== '0) begin
            n_fails++;
            $display("FAIL R1: row_valid=%0d row_sum=%0h expected 0 0", row_valid, row_sum);
        end
        rst_n = 1'b1;
        idle(3, "R1");

        // R2, R9: one-step rows with a single non-zero slice
        for (int k = 0; k < SLICES; k++) begin
            logic [CW-1:0] c = '0;
            c[k*CODE_W +: CODE_W] = CODE_W'(10'h2A5 + k);
            cyc(1, 1, 1, c, "R2");
            idle(1, "R8");
        end
        cyc(1, 1, 1, '0, "R9");
        idle(2, "R8");

        // R3: multi-step rows of several lengths
        run_row(STEPS, "R3", 0, 0);
        run_row(2, "R3", 0, 0);
        run_row(5, "R3", 0, 0);
        idle(3, "R8");

        // R4: an unfinished row is abandoned by a new opening step
        run_row(4, "R4", 0, 0);
        for (int j = 0; j < 3; j++) cyc(1, j == 0, 0, rand_codes(), "R4");
        run_row(3, "R4", 0, 0);
        idle(2, "R8");

        // R6: gaps inside rows
        for (int r = 0; r < 6; r++) run_row(2 + $urandom % (STEPS - 1), "R6", 1, 0);
        idle(2, "R8");

        // R7: back-to-back rows, including one-step rows
        for (int r = 0; r < 8; r++) run_row(1 + $urandom % 4, "R7", 0, 0);
        idle(3, "R8");

        // R10: full-scale row over the maximum number of steps
        run_row(STEPS, "R10", 0, 1);
        idle(3, "R8");

        // Random mix of lengths, gaps and back-to-back rows
        for (int r = 0; r < 40; r++) begin
            run_row(1 + $urandom % STEPS, "R3", 1, 0);
            if ($urandom % 2) idle(1 + $urandom % 3, "R8");
        end
        idle(4, "R8");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule